// File: doc/BRIEF.md
# Half-Rate Three-Tap Window Adder

This block sums a sliding window of three unsigned 8-bit samples, producing b[i] + b[i+1] + b[i+2]. The producer can hand over at most two samples per clock. Each window therefore arrives as two beats. The first beat carries the two leading samples on both input lanes. The second beat carries the trailing sample on the low lane only.

Delay registers hold the leading pair until the trailing sample arrives. After that, a short adder pipeline forms the sum. Stages that hold no complete window pass junk down the pipeline. A per-stage valid bit travels alongside the data, and only real results raise the output flag. The block tracks the beat type itself and shows it on an output, so the producer always knows whether a pair or a single sample is due next.

Top module: `halfrate_tap3`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, leaves `sumValid` low and `wantPair` high (pair expected next) from the following cycle on.
- R2: Every result equals the full-precision unsigned sum of the three window samples in 10 bits, including the largest case 255+255+255 = 765.
- R3: The beat type flips on every clock where `inValid` is high: a pair beat when `wantPair` is 1, a single beat when it is 0. When `inValid` is low, `wantPair` keeps its value.
- R4: A result becomes visible on `sumOut`/`sumValid` right after the third rising edge that follows the edge accepting the single beat. With back-to-back beats, the first result therefore appears in the fifth cycle counted from the cycle the pair is presented.
- R5: `sumValid` is low on every cycle that does not carry a result. Under continuous input, valid results appear on alternate cycles.
- R6: On a single beat, `inHi` is ignored; only `inLo` supplies the trailing sample.
- R7: Idle cycles between a pair beat and its single beat do not disturb the held pair. The result is the same as with no gap.
- R8: A reset asserted while windows are in flight discards them. No `sumValid` pulse appears for them afterwards.
- R9: `sumValid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Beat present on the lanes this cycle |
| inLo | input | 8 | Leading sample (pair beat) or trailing sample (single beat) |
| inHi | input | 8 | Second sample of a pair beat; ignored on a single beat |
| wantPair | output | 1 | 1 when the next valid beat is taken as a pair |
| sumOut | output | 10 | Window sum |
| sumValid | output | 1 | `sumOut` holds a real result this cycle |

## Verification
The bench checks every cycle against a schedule of expected results: each cycle is either a specific sum or a required low flag. A design that lets junk slots raise the flag, or that shifts the latency by one register, fails on the very first mismatched cycle. Directed cases target four faults:
- Saturated samples catch a sum truncated to 9 bits.
- A garbage high lane on single beats catches a design that adds `inHi`.
- Idle gaps between the two beats catch a pair register that is overwritten or clocked without its enable.
- A reset during the flight of two windows catches valid bits that survive reset and emit stale sums.

// File: rtl/ttsum_pkg.sv
package ttsum_pkg;

  // Strobes from the control unit to the datapath, one per register group.
  typedef struct packed {
    logic loadPair;     // capture the two leading samples
    logic loadAlign;    // capture the trailing sample, move the pair into delay regs
    logic loadPartial;  // add the pair, delay the trailing sample
    logic loadFinal;    // add partial and trailing sample
    logic loadOut;      // update the output register
  } strobe_t;

endpackage

// File: rtl/ttsum_ctrl.sv
module ttsum_ctrl
  import ttsum_pkg::*;
#(
  parameter int ALIGN_STAGES = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    wantPair,
  output logic    outValid
);

  localparam int LastStage = ALIGN_STAGES - 1;

  logic phaseSingle;                 // 0: pair expected, 1: single expected
  logic [ALIGN_STAGES-1:0] stageValid;
  logic outValidReg;
  logic singleBeat;

  assign singleBeat = inValid & phaseSingle;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseSingle <= 1'b0;
    end else if (inValid) begin
      phaseSingle <= ~phaseSingle;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid[0] <= 1'b0;
    end else begin
      stageValid[0] <= singleBeat;
    end
  end

  // Valid bits walk with the data; junk slots carry a zero.
  for (genvar s = 1; s < ALIGN_STAGES; s++) begin : g_validShift
    always_ff @(posedge clk) begin
      if (rst) begin
        stageValid[s] <= 1'b0;
      end else begin
        stageValid[s] <= stageValid[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValidReg <= 1'b0;
    end else begin
      outValidReg <= stageValid[LastStage];
    end
  end

  always_comb begin
    strobe.loadPair    = inValid & ~phaseSingle;
    strobe.loadAlign   = singleBeat;
    strobe.loadPartial = stageValid[0];
    strobe.loadFinal   = stageValid[1];
    strobe.loadOut     = stageValid[LastStage];
  end

  assign wantPair = ~phaseSingle;
  assign outValid = outValidReg;

endmodule

// File: rtl/ttsum_datapath.sv
module ttsum_datapath
  import ttsum_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strobe,
  input  logic [SAMPLE_W-1:0]   inLo,
  input  logic [SAMPLE_W-1:0]   inHi,
  output logic [SAMPLE_W+1:0]   sumOut
);

  localparam int PartW = SAMPLE_W + 1;
  localparam int SumW  = SAMPLE_W + 2;

  logic [SAMPLE_W-1:0] pairLead, pairNext;     // held pair from the pair beat
  logic [SAMPLE_W-1:0] alignLead, alignNext;   // pair re-timed to the single beat
  logic [SAMPLE_W-1:0] trailSample, trailDly;
  logic [PartW-1:0]    partialSum;
  logic [SumW-1:0]     finalSum, outReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pairLead <= '0;
      pairNext <= '0;
    end else if (strobe.loadPair) begin
      pairLead <= inLo;
      pairNext <= inHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alignLead   <= '0;
      alignNext   <= '0;
      trailSample <= '0;
    end else if (strobe.loadAlign) begin
      alignLead   <= pairLead;
      alignNext   <= pairNext;
      trailSample <= inLo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      partialSum <= '0;
      trailDly   <= '0;
    end else if (strobe.loadPartial) begin
      partialSum <= PartW'(alignLead) + PartW'(alignNext);
      trailDly   <= trailSample;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      finalSum <= '0;
    end else if (strobe.loadFinal) begin
      finalSum <= SumW'(partialSum) + SumW'(trailDly);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outReg <= '0;
    end else if (strobe.loadOut) begin
      outReg <= finalSum;
    end
  end

  assign sumOut = outReg;

endmodule

// File: rtl/halfrate_tap3.sv
module halfrate_tap3
  import ttsum_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLo,
  input  logic [SAMPLE_W-1:0] inHi,
  output logic                wantPair,
  output logic [SAMPLE_W+1:0] sumOut,
  output logic                sumValid
);

  strobe_t strobe;

  ttsum_ctrl #(.ALIGN_STAGES(3)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .wantPair (wantPair),
    .outValid (sumValid)
  );

  ttsum_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inLo   (inLo),
    .inHi   (inHi),
    .sumOut (sumOut)
  );

endmodule

// File: rtl/halfrate_tap3_chk.sv
module halfrate_tap3_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                wantPair,
  input logic [SAMPLE_W+1:0] sumOut,
  input logic                sumValid
);

  localparam int MaxSum = 3 * ((1 << SAMPLE_W) - 1);

  // R1: reset clears flag and phase
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sumValid && wantPair));

  // R2: result never exceeds three full-scale samples
  a_r2_sum_range: assert property (@(posedge clk) disable iff (rst)
    sumValid |-> (int'(sumOut) <= MaxSum));

  // R3: each accepted beat flips the beat type
  a_r3_phase_flip: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (wantPair != $past(wantPair)));

  // R3: idle cycles keep the beat type
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(wantPair));

  // R4: single beat produces a result three edges later
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (inValid && !wantPair) |=> ##3 sumValid);

  // R9: results never sit on adjacent cycles
  a_r9_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    sumValid |=> !sumValid);

endmodule

bind halfrate_tap3 halfrate_tap3_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .wantPair (wantPair),
  .sumOut   (sumOut),
  .sumValid (sumValid)
);

// File: tb/sim_halfrate_tap3.sv
module sim_halfrate_tap3;

  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inLo = '0;
  logic [7:0] inHi = '0;
  logic       wantPair;
  logic [9:0] sumOut;
  logic       sumValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  bit expPair = 1'b1;
  int heldLo = 0;
  int heldHi = 0;
  int expVal [int];

  halfrate_tap3 u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inLo(inLo), .inHi(inHi),
    .wantPair(wantPair), .sumOut(sumOut), .sumValid(sumValid)
  );

  always #(ClkPeriod/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle monitor: R2/R4 on scheduled cycles, R5 elsewhere.
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (expVal.exists(cyc)) begin
        chk(sumValid === 1'b1, "R4 result flag", int'(sumValid), 1);
        chk(int'(sumOut) == expVal[cyc], "R2 sum value", int'(sumOut), expVal[cyc]);
        expVal.delete(cyc);
      end else begin
        chk(sumValid === 1'b0, "R5 junk cycle flag", int'(sumValid), 0);
      end
    end
  end

  // One beat; checks R3 phase before driving.
  task automatic beat(input bit v, input int lo, input int hi);
    @(negedge clk);
    chk(wantPair === expPair, "R3 beat type", int'(wantPair), int'(expPair));
    inValid = v;
    inLo = 8'(lo);
    inHi = 8'(hi);
    if (v) begin
      if (expPair) begin
        heldLo = lo;
        heldHi = hi;
      end else begin
        expVal[cyc + 4] = heldLo + heldHi + lo;
      end
      expPair = ~expPair;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) beat(1'b0, 8'h5A, 8'hA5);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    for (int k = 1; k <= 6; k++) if (expVal.exists(cyc + k)) expVal.delete(cyc + k);
    expPair = 1'b1;
    @(negedge clk);
    chk(sumValid === 1'b0, "R1 flag after reset", int'(sumValid), 0);
    chk(wantPair === 1'b1, "R1 phase after reset", int'(wantPair), 1);
    rst = 1'b0;
  endtask

  task automatic t_basic();   // R2, R4
    beat(1'b1, 10, 20);
    beat(1'b1, 30, 0);
    idle(6);
    beat(1'b1, 255, 255);
    beat(1'b1, 255, 0);
    idle(6);
  endtask

  task automatic t_stream();  // R5, R9: sliding windows back to back
    for (int i = 0; i < 8; i++) begin
      beat(1'b1, (i * 37 + 5) % 256, ((i + 1) * 37 + 5) % 256);
      beat(1'b1, ((i + 2) * 37 + 5) % 256, 0);
    end
    idle(6);
  endtask

  task automatic t_ignore_hi();  // R6
    beat(1'b1, 1, 2);
    beat(1'b1, 3, 255);
    beat(1'b1, 100, 50);
    beat(1'b1, 7, 128);
    idle(6);
  endtask

  task automatic t_gap();  // R7, R3 idle hold
    beat(1'b1, 200, 100);
    idle(3);
    beat(1'b1, 60, 77);
    idle(1);
    beat(1'b1, 9, 8);
    idle(5);
    beat(1'b1, 7, 0);
    idle(6);
  endtask

  task automatic t_reset_mid();  // R8
    beat(1'b1, 11, 22);
    beat(1'b1, 33, 0);
    beat(1'b1, 44, 55);
    beat(1'b1, 66, 0);
    do_reset();
    idle(6);
    beat(1'b1, 1, 1);
    beat(1'b1, 1, 0);
    idle(6);
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(sumValid === 1'b0, "R1 flag in reset", int'(sumValid), 0);
    chk(wantPair === 1'b1, "R1 phase in reset", int'(wantPair), 1);
    rst = 1'b0;
    monOn = 1'b1;
    t_basic();
    t_stream();
    t_ignore_hi();
    t_gap();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule